// File: doc/BRIEF.md
# Banked Bus Memory Slave with Error Responder

This block is a synthesizable slave for a single-master pipelined system bus (AHB-Lite style). It holds between one and four RAM banks. Each bank owns one contiguous 1 KB byte window, and bank k starts at byte address k×400h. A decoder captures the target bank during each accepted address phase. In the following data phase a multiplexer returns the read data and the response of that bank. Any address above the last configured bank goes to a built-in error responder, which rejects every access to it.

The lowest four byte addresses of every bank form a protected word. Reads of this word succeed. Writes to it are refused with an error and leave the bank unchanged. Transfers are whole words of the configured data width. An address phase is accepted on every clock edge where the slave's ready output is high. Write data arrives one cycle later and is stored at the address captured in that earlier address phase, so write and read transfers can run back to back without gaps.

Top module: `ahbBankMem`

## Requirements
- R1: During and right after reset, ready is 1, the error flag is 0 and read data is 0. Every bank word reads as 0 until it is written.
- R2: A write with HTRANS NONSEQ (2) or SEQ (3) to a mapped, writable address, followed by a read of the same address, returns the written word. Both transfers get a zero-wait OKAY response (ready 1, error 0).
- R3: Byte address A belongs to bank A/400h, at word (A mod 400h)/(DATA_W/8). Equal offsets in different banks hold independent words.
- R4: A write whose offset inside a bank is 000h–003h receives an ERROR response, and a later read of that word returns its old content.
- R5: An access at or above NUM_BANKS×400h, read or write, receives an ERROR response and changes no bank word.
- R6: An ERROR lasts exactly two cycles. In the first cycle ready is 0 and the error flag is 1. In the second cycle both are 1.
- R7: A transfer with HTRANS IDLE (0) or BUSY (1) receives a zero-wait OKAY and neither reads nor writes any bank. Data driven on the write-data bus during its data phase is discarded.
- R8: Write data is stored at the address of the preceding address phase. A read issued directly after a write to the same address returns the new word.
- R9: A read of the protected offsets 000h–003h receives a zero-wait OKAY with the stored word.
- R10: Read data is 0 in every data phase that is not a successful read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| haddr | input | ADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer kind: 0 idle, 1 busy, 2 nonsequential, 3 sequential |
| hwrite | input | 1 | 1 for write, 0 for read |
| hwdata | input | DATA_W | Write data of the current data phase |
| hrdata | output | DATA_W | Read data of the current data phase |
| hready | output | 1 | 1 when the current data phase completes |
| hresp | output | 1 | 1 when an ERROR response is in progress |

## Verification
A bank select, word index or error flag captured wrongly in the address phase shows up at the ports in the very next data phase. It appears as a wrong read word, a missing or extra error, or a ready that drops when it should not. A write that lands in the wrong place or is not suppressed stays hidden until that word is read back. For this reason each write pattern is followed by reads of the target word, the protected word and the same offset in other banks. A fault in the error sequencer alters ready and error within one or two cycles.

// File: rtl/ahbBankMemPkg.sv
package ahbBankMemPkg;

  localparam int BANK_BYTES = 1024;
  localparam int LOCAL_BITS = 10;
  localparam int RO_BYTES   = 4;

  typedef enum logic [1:0] {
    RESP_OK       = 2'd0,
    RESP_ERR_WAIT = 2'd1,
    RESP_ERR_DONE = 2'd2
  } respState_e;

  typedef struct packed {
    logic       rdEn;
    logic       wrEn;
    logic [1:0] bank;
  } memStrobe_t;

endpackage

// File: rtl/ahbBankMemRam.sv
module ahbBankMemRam #(
  parameter int DATA_W    = 32,
  parameter int WORD_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [WORD_BITS-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << WORD_BITS;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wrEn) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = rdEn ? cells[addr] : '0;
endmodule

// File: rtl/ahbBankMemCtrl.sv
module ahbBankMemCtrl
  import ahbBankMemPkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  output memStrobe_t        strobe,
  output logic [LOCAL_BITS-$clog2(DATA_W/8)-1:0] dphWord,
  output logic              hready,
  output logic              hresp
);
  localparam int OFFSET_BITS = $clog2(DATA_W / 8);
  localparam int WORD_BITS   = LOCAL_BITS - OFFSET_BITS;
  localparam int MAP_LIMIT   = NUM_BANKS * BANK_BYTES;

  respState_e state;
  logic       dphValid;
  logic       dphWrite;
  logic [1:0] dphBank;

  logic active;
  logic mapped;
  logic roHit;
  logic decErr;

  always_comb begin
    active = htrans[1];
    mapped = haddr < ADDR_W'(MAP_LIMIT);
    roHit  = haddr[LOCAL_BITS-1:0] < LOCAL_BITS'(RO_BYTES);
    decErr = !mapped || (hwrite && roHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RESP_OK;
      dphValid <= 1'b0;
      dphWrite <= 1'b0;
      dphBank  <= '0;
      dphWord  <= '0;
    end else if (state == RESP_ERR_WAIT) begin
      state    <= RESP_ERR_DONE;
      dphValid <= 1'b0;
    end else begin
      dphValid <= active && !decErr;
      state    <= (active && decErr) ? RESP_ERR_WAIT : RESP_OK;
      dphWrite <= hwrite;
      dphBank  <= haddr[LOCAL_BITS +: 2];
      dphWord  <= haddr[LOCAL_BITS-1:OFFSET_BITS];
    end
  end

  always_comb begin
    strobe.rdEn = dphValid && !dphWrite;
    strobe.wrEn = dphValid && dphWrite;
    strobe.bank = dphBank;
    hready      = (state != RESP_ERR_WAIT);
    hresp       = (state != RESP_OK);
  end
endmodule

// File: rtl/ahbBankMemDatapath.sv
module ahbBankMemDatapath
  import ahbBankMemPkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [LOCAL_BITS-$clog2(DATA_W/8)-1:0] dphWord,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata
);
  localparam int WORD_BITS = LOCAL_BITS - $clog2(DATA_W / 8);

  logic [DATA_W-1:0] bankRdata [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic hit;
    assign hit = (strobe.bank == 2'(g));
    ahbBankMemRam #(
      .DATA_W   (DATA_W),
      .WORD_BITS(WORD_BITS)
    ) uRam (
      .clk  (clk),
      .rstN (rstN),
      .wrEn (strobe.wrEn && hit),
      .rdEn (strobe.rdEn && hit),
      .addr (dphWord),
      .wdata(hwdata),
      .rdata(bankRdata[g])
    );
  end

  always_comb begin
    hrdata = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (strobe.bank == 2'(i)) hrdata = bankRdata[i];
    end
  end
endmodule

// File: rtl/ahbBankMem.sv
module ahbBankMem
  import ahbBankMemPkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready,
  output logic              hresp
);
  localparam int WORD_BITS = LOCAL_BITS - $clog2(DATA_W / 8);

  memStrobe_t           strobe;
  logic [WORD_BITS-1:0] dphWord;

  ahbBankMemCtrl #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .haddr  (haddr),
    .htrans (htrans),
    .hwrite (hwrite),
    .strobe (strobe),
    .dphWord(dphWord),
    .hready (hready),
    .hresp  (hresp)
  );

  ahbBankMemDatapath #(
    .NUM_BANKS(NUM_BANKS),
    .DATA_W   (DATA_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dphWord(dphWord),
    .hwdata (hwdata),
    .hrdata (hrdata)
  );
endmodule

// File: rtl/ahbBankMemChecker.sv
module ahbBankMemChecker #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [DATA_W-1:0] hrdata,
  input logic              hready,
  input logic              hresp
);
  localparam int MAP_LIMIT = NUM_BANKS * 1024;

  logic acceptAct;
  assign acceptAct = hready && htrans[1];

  assert_wait_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    !hready |-> hresp);

  assert_err_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    !hready |=> (hready && hresp));

  assert_unmapped_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acceptAct && haddr >= ADDR_W'(MAP_LIMIT)) |=> (!hready && hresp));

  assert_ro_write_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    (acceptAct && hwrite && haddr[9:0] < 10'd4) |=> (!hready && hresp));

  assert_idle_okay_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hready && !htrans[1]) |=> (hready && !hresp && hrdata == '0));

  assert_write_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (acceptAct && hwrite) |=> (hrdata == '0));
endmodule

bind ahbBankMem ahbBankMemChecker #(
  .NUM_BANKS(NUM_BANKS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) uChecker (
  .clk   (clk),
  .rstN  (rstN),
  .haddr (haddr),
  .htrans(htrans),
  .hwrite(hwrite),
  .hrdata(hrdata),
  .hready(hready),
  .hresp (hresp)
);

// File: tb/ahbBankMem_test.sv
module ahbBankMem_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [1:0] T_IDLE = 2'd0, T_BUSY = 2'd1, T_NSEQ = 2'd2, T_SEQ = 2'd3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [1:0]    htrans = T_IDLE;
  logic          hwrite = 1'b0;
  logic [DW-1:0] hwdata = '0;
  logic [DW-1:0] hrdata;
  logic          hready;
  logic          hresp;

  int    checks = 0;
  int    fails = 0;
  string curTag = "R1";
  logic [DW-1:0] nextData = '0;

  // behavioural reference
  int            mState = 0;   // 0 ok, 1 error first cycle, 2 error second cycle
  bit            mValid = 0;
  bit            mWrite = 0;
  int            mWord = 0;
  logic [DW-1:0] modelMem [int];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ahbBankMem #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  function automatic logic [DW-1:0] memRead(int w);
    return modelMem.exists(w) ? modelMem[w] : '0;
  endfunction

  task automatic check(string tag, logic [DW+1:0] act, logic [DW+1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: {hready,hresp,hrdata} actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mValid = 0; mWrite = 0; mWord = 0;
    end else begin
      if (mValid && mWrite) modelMem[mWord] = hwdata;
      if (mState == 1) begin
        mState = 2; mValid = 0;
      end else if (htrans[1]) begin
        if (haddr >= NB * 1024 || (hwrite && haddr[9:0] < 4)) begin
          mState = 1; mValid = 0;
        end else begin
          mState = 0; mValid = 1; mWrite = hwrite; mWord = int'(haddr >> 2);
        end
      end else begin
        mState = 0; mValid = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [DW-1:0] expData;
      expData = (mValid && !mWrite) ? memRead(mWord) : '0;
      check(curTag, {hready, hresp, hrdata}, {mState != 1, mState != 0, expData});
    end
  end

  // drive one address phase; data is the write data for this transfer,
  // placed on the bus during its data phase
  task automatic step(logic [1:0] tr, logic wr, logic [AW-1:0] a, logic [DW-1:0] d);
    bit done;
    htrans = tr; hwrite = wr; haddr = a;
    hwdata = nextData; nextData = d;
    done = 0;
    while (!done) begin
      done = hready;
      @(posedge clk);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {hready, hresp, hrdata}, {1'b1, 1'b0, {DW{1'b0}}});
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1", {hready, hresp, hrdata}, {1'b1, 1'b0, {DW{1'b0}}});

    curTag = "R1";  // fresh words read as zero
    step(T_NSEQ, 0, 32'h0000_0044, '0);
    step(T_NSEQ, 0, 32'h0000_0444, '0);

    curTag = "R2";
    step(T_NSEQ, 1, 32'h0000_0010, 32'hA5A5_0001);
    step(T_NSEQ, 0, 32'h0000_0010, '0);
    step(T_IDLE, 0, '0, '0);

    curTag = "R8";
    step(T_NSEQ, 1, 32'h0000_0020, 32'h1111_2222);
    step(T_SEQ,  1, 32'h0000_0024, 32'h3333_4444);
    step(T_SEQ,  0, 32'h0000_0024, '0);
    step(T_SEQ,  0, 32'h0000_0020, '0);
    step(T_NSEQ, 1, 32'h0000_0028, 32'hDEAD_BEEF);
    step(T_NSEQ, 0, 32'h0000_0028, '0);

    curTag = "R3";
    step(T_NSEQ, 1, 32'h0000_0410, 32'hB0B0_1234);
    step(T_NSEQ, 1, 32'h0000_03FC, 32'hC0C0_5678);
    step(T_NSEQ, 0, 32'h0000_0010, '0);
    step(T_NSEQ, 0, 32'h0000_0410, '0);
    step(T_NSEQ, 0, 32'h0000_03FC, '0);
    step(T_NSEQ, 0, 32'h0000_07FC, '0);

    curTag = "R10";
    step(T_NSEQ, 1, 32'h0000_0404, 32'h0F0F_0F0F);
    step(T_IDLE, 0, '0, '0);

    curTag = "R4";
    step(T_NSEQ, 1, 32'h0000_0000, 32'hFFFF_0000);
    step(T_NSEQ, 1, 32'h0000_0402, 32'hFFFF_0001);
    step(T_NSEQ, 0, 32'h0000_0400, '0);
    curTag = "R9";
    step(T_NSEQ, 0, 32'h0000_0000, '0);
    step(T_NSEQ, 0, 32'h0000_0004, '0);

    curTag = "R6";
    step(T_NSEQ, 1, 32'h0000_0003, 32'h1234_5678);
    step(T_NSEQ, 0, 32'h0000_0010, '0);

    curTag = "R5";
    step(T_NSEQ, 1, 32'h0000_0810, 32'h5555_AAAA);
    step(T_NSEQ, 0, 32'hFFFF_0010, '0);
    step(T_NSEQ, 0, 32'h0000_0010, '0);
    step(T_NSEQ, 0, 32'h0000_0410, '0);

    curTag = "R7";
    step(T_BUSY, 1, 32'h0000_0030, 32'h7777_7777);
    step(T_IDLE, 1, 32'h0000_0014, 32'h8888_8888);
    step(T_IDLE, 0, 32'h0000_0010, 32'h9999_9999);
    step(T_NSEQ, 0, 32'h0000_0030, '0);
    step(T_NSEQ, 0, 32'h0000_0014, '0);
    step(T_NSEQ, 0, 32'h0000_0010, '0);
    step(T_IDLE, 0, '0, '0);
    step(T_IDLE, 0, '0, '0);

    finishRun();
  end
endmodule